// File: doc/BRIEF.md
# Dual-channel converter configuration serial port

This block is the serial control port of a two-channel data converter. It runs on the system clock and oversamples the chip-select, serial-clock and data-in pins. It accepts frames that open with a 16-bit instruction word and continue with byte-wide register data. The single data pin is presented as a separate input, output and output-enable, so an I/O pad can merge them into one bidirectional line. Register contents leave the block as registered control outputs that set the output data format, the internal reference and the test-pattern generator of each channel.

Most configuration registers exist once per channel. A channel-select register decides which copies a write updates and which copy a read returns. A host can therefore program both channels with one frame, or tune one channel alone.

After reset the port is in a static pin-control mode. In this mode the serial-clock level sets the data format directly. The first falling edge of chip-select leaves that mode for good, and the format holds whatever level the serial clock had at that moment.

Top module: `cfg_spi_slave`

## Requirements
- R1: After reset the block is in pin-control mode (`ctl_pin_mode` = 1), `spi_sdio_oe` is 0, and all channel controls are zero except the format. The format follows R2.
- R2: While pin-control mode lasts, each channel's 2-bit format equals {0, level of `spi_sclk`}. The first low level on `spi_cs_n` clears pin-control mode. It never returns. The format keeps the value it had when the mode ended.
- R3: A frame opens with a 16-bit instruction word, most significant bit first, sampled on rising `spi_sclk`. Bit 15 is the direction (1 = read, 0 = write), bits 14:13 are the length code and bits 12:0 are the full register address. An address that differs from a mapped one only in its upper bits is unmapped.
- R4: Length codes 00, 01 and 10 move 1, 2 and 3 data bytes. Bytes beyond that count are ignored. Code 11 moves bytes until `spi_cs_n` rises. The address counts down by one after each byte.
- R5: The channel-select register at 0x0003 has bit 0 for channel A and bit 1 for channel B. It resets to both set. Bits 7:2 always read 1.
- R6: A write to a per-channel register updates every channel whose select bit is 1. With no bit set, no channel changes.
- R7: A read of a per-channel register returns channel A's copy when bit 0 of 0x0003 is set, and channel B's copy otherwise.
- R8: Read data is driven most significant bit first. It starts at the falling `spi_sclk` edge after the last instruction bit, and each later falling edge advances one bit. `spi_sdio_oe` is 0 whenever `spi_cs_n` is high.
- R9: The per-channel register layout is as follows. 0x0008 holds the reference enable in bit 3 and the gain code in bits 2:0, and bits 7:4 read 0. 0x0011 holds the format in bits 1:0. 0x0014 holds the test-pattern select in bits 2:0. 0x0015 holds pattern bits 11:4. 0x0016 holds pattern bits 3:0 in its bits 3:0. Unused bits ignore writes and read 0.
- R10: A write to an unmapped address changes nothing, and a read from one returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than eight times the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock; static format level in pin-control mode |
| spi_sdio_i | input | 1 | Serial data from the host |
| spi_sdio_o | output | 1 | Serial read data to the host |
| spi_sdio_oe | output | 1 | Drive enable for the data pad |
| ctl_pin_mode | output | 1 | 1 while pin-control mode is active |
| ch_fmt | output | 2*NCH | Data format per channel, channel A in the low bits |
| ch_ref_en | output | NCH | Internal reference enable per channel |
| ch_ref_gain | output | 3*NCH | Reference gain code per channel |
| ch_tp_sel | output | 3*NCH | Test-pattern select per channel |
| ch_tp_word | output | 12*NCH | User test pattern per channel |

## Verification
The hardest state to reach is the exit from pin-control mode with a chosen format. The serial clock has to be held high while chip-select falls, and that falling edge also opens a frame that must end cleanly without any clock edge. The bench holds the clock high, pulses chip-select, and then toggles the clock with chip-select high to show that the captured format stays put. Steering is checked by moving the channel-select register through B only, A only and neither, and by watching both channels' outputs after each write. A long streamed write runs the descending address off the mapped range into an unmapped one.

// File: rtl/cfgspi_pkg.sv
package cfgspi_pkg;

  localparam int ADDR_W    = 13;
  localparam int BYTE_W    = 8;
  localparam int INSTR_W   = 16;
  localparam int FMT_W     = 2;
  localparam int GAIN_W    = 3;
  localparam int TPSEL_W   = 3;
  localparam int TPWORD_W  = 12;
  localparam int TPLO_W    = TPWORD_W - BYTE_W;

  localparam logic [ADDR_W-1:0] A_CHIDX = 13'h0003;
  localparam logic [ADDR_W-1:0] A_REF   = 13'h0008;
  localparam logic [ADDR_W-1:0] A_FMT   = 13'h0011;
  localparam logic [ADDR_W-1:0] A_TPSEL = 13'h0014;
  localparam logic [ADDR_W-1:0] A_TPHI  = 13'h0015;
  localparam logic [ADDR_W-1:0] A_TPLO  = 13'h0016;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_INSTR = 2'd1,
    FR_DATA  = 2'd2,
    FR_DONE  = 2'd3
  } fr_state_e;

  typedef struct packed {
    logic [FMT_W-1:0]    fmt;
    logic                ref_en;
    logic [GAIN_W-1:0]   gain;
    logic [TPSEL_W-1:0]  tp_sel;
    logic [TPWORD_W-1:0] tp_word;
  } chan_cfg_t;

endpackage

// File: rtl/cfgspi_sync.sv
module cfgspi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdio,
  output logic cs_s,
  output logic sclk_s,
  output logic sdio_s,
  output logic cs_fall,
  output logic sclk_rise,
  output logic sclk_fall
);

  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] RST_VAL = 3'b001;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] pipe [STAGES];
  logic [NSIG-1:0] prev;

  assign raw = {sdio, sclk, cs_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
      prev <= RST_VAL;
    end else begin
      pipe[0] <= raw;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prev <= pipe[STAGES-1];
    end
  end

  assign cs_s      = pipe[STAGES-1][0];
  assign sclk_s    = pipe[STAGES-1][1];
  assign sdio_s    = pipe[STAGES-1][2];
  assign cs_fall   = prev[0] & ~pipe[STAGES-1][0];
  assign sclk_rise = ~prev[1] & pipe[STAGES-1][1];
  assign sclk_fall = prev[1] & ~pipe[STAGES-1][1];

endmodule

// File: rtl/cfgspi_frame.sv
module cfgspi_frame
  import cfgspi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              sdio_s,
  input  logic              cs_fall,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sdio_o,
  output logic              sdio_oe
);

  localparam int CNT_W = $clog2(INSTR_W);
  localparam logic [CNT_W-1:0] LAST_INSTR = CNT_W'(INSTR_W - 1);
  localparam logic [CNT_W-1:0] LAST_DATA  = CNT_W'(BYTE_W - 1);

  fr_state_e          st;
  logic [CNT_W-1:0]   bitcnt;
  logic [INSTR_W-1:0] shreg;
  logic               rw;
  logic [1:0]         len;
  logic [1:0]         byte_idx;
  logic [ADDR_W-1:0]  addr;
  logic [BYTE_W-1:0]  out_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= FR_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      rw       <= 1'b0;
      len      <= '0;
      byte_idx <= '0;
      addr     <= '0;
      out_sr   <= '0;
      sdio_oe  <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (cs_s) begin
        st      <= FR_IDLE;
        sdio_oe <= 1'b0;
      end else if (cs_fall) begin
        st     <= FR_INSTR;
        bitcnt <= '0;
      end else if (sclk_rise) begin
        shreg <= {shreg[INSTR_W-2:0], sdio_s};
        case (st)
          FR_INSTR: begin
            if (bitcnt == LAST_INSTR) begin
              rw       <= shreg[INSTR_W-2];
              len      <= shreg[INSTR_W-3:INSTR_W-4];
              addr     <= {shreg[ADDR_W-2:0], sdio_s};
              st       <= FR_DATA;
              bitcnt   <= '0;
              byte_idx <= '0;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
          FR_DATA: begin
            if (bitcnt == LAST_DATA) begin
              bitcnt <= '0;
              if (!rw) begin
                wr_en   <= 1'b1;
                wr_addr <= addr;
                wr_data <= {shreg[BYTE_W-2:0], sdio_s};
              end
              if (len != 2'b11 && byte_idx == len) begin
                st <= FR_DONE;
              end else begin
                byte_idx <= byte_idx + 1'b1;
                addr     <= addr - ADDR_W'(1);
              end
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
          default: ;
        endcase
      end else if (sclk_fall && st == FR_DATA && rw) begin
        if (bitcnt == '0) begin
          out_sr  <= rd_data;
          sdio_oe <= 1'b1;
        end else begin
          out_sr <= {out_sr[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign rd_addr = addr;
  assign sdio_o  = out_sr[BYTE_W-1];

  p_hiz_cs_high_r8: assert property (@(posedge clk) disable iff (rst)
    (cs_s && $past(cs_s)) |-> !sdio_oe);

  p_no_write_in_read_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !rw);

  p_quiet_after_last_r4: assert property (@(posedge clk) disable iff (rst)
    (st == FR_DONE) |=> !wr_en);

endmodule

// File: rtl/cfgspi_regs.sv
module cfgspi_regs
  import cfgspi_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs_fall,
  input  logic                    sclk_s,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [BYTE_W-1:0]       wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [BYTE_W-1:0]       rd_data,
  output logic                    pin_mode,
  output logic [NCH*FMT_W-1:0]    ch_fmt,
  output logic [NCH-1:0]          ch_ref_en,
  output logic [NCH*GAIN_W-1:0]   ch_ref_gain,
  output logic [NCH*TPSEL_W-1:0]  ch_tp_sel,
  output logic [NCH*TPWORD_W-1:0] ch_tp_word
);

  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int RSV_W = BYTE_W - NCH;

  logic [NCH-1:0]            chidx;
  chan_cfg_t [NCH-1:0]       cfg_q;
  logic [SEL_W-1:0]          rsel;
  chan_cfg_t                 rcfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_mode <= 1'b1;
      chidx    <= '1;
      cfg_q    <= '0;
    end else begin
      if (cs_fall) pin_mode <= 1'b0;
      if (wr_en && wr_addr == A_CHIDX) chidx <= wr_data[NCH-1:0];
      for (int c = 0; c < NCH; c++) begin
        if (pin_mode) cfg_q[c].fmt <= {1'b0, sclk_s};
        if (wr_en && chidx[c]) begin
          case (wr_addr)
            A_REF: begin
              cfg_q[c].ref_en <= wr_data[GAIN_W];
              cfg_q[c].gain   <= wr_data[GAIN_W-1:0];
            end
            A_FMT:   cfg_q[c].fmt <= wr_data[FMT_W-1:0];
            A_TPSEL: cfg_q[c].tp_sel <= wr_data[TPSEL_W-1:0];
            A_TPHI:  cfg_q[c].tp_word[TPWORD_W-1:TPLO_W] <= wr_data;
            A_TPLO:  cfg_q[c].tp_word[TPLO_W-1:0] <= wr_data[TPLO_W-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rsel = SEL_W'(NCH - 1);
    for (int c = NCH - 1; c >= 0; c--) begin
      if (chidx[c]) rsel = SEL_W'(c);
    end
  end

  assign rcfg = cfg_q[rsel];

  always_comb begin
    case (rd_addr)
      A_CHIDX: rd_data = {{RSV_W{1'b1}}, chidx};
      A_REF:   rd_data = BYTE_W'({rcfg.ref_en, rcfg.gain});
      A_FMT:   rd_data = BYTE_W'(rcfg.fmt);
      A_TPSEL: rd_data = BYTE_W'(rcfg.tp_sel);
      A_TPHI:  rd_data = rcfg.tp_word[TPWORD_W-1:TPLO_W];
      A_TPLO:  rd_data = BYTE_W'(rcfg.tp_word[TPLO_W-1:0]);
      default: rd_data = '0;
    endcase
  end

  for (genvar c = 0; c < NCH; c++) begin : g_out
    assign ch_fmt[c*FMT_W +: FMT_W]          = cfg_q[c].fmt;
    assign ch_ref_en[c]                      = cfg_q[c].ref_en;
    assign ch_ref_gain[c*GAIN_W +: GAIN_W]   = cfg_q[c].gain;
    assign ch_tp_sel[c*TPSEL_W +: TPSEL_W]   = cfg_q[c].tp_sel;
    assign ch_tp_word[c*TPWORD_W +: TPWORD_W] = cfg_q[c].tp_word;
  end

  p_pin_mode_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    !pin_mode |=> !pin_mode);

  p_nosel_no_change_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && chidx == '0 && !pin_mode) |=> $stable(cfg_q));

endmodule

// File: rtl/cfg_spi_slave.sv
module cfg_spi_slave
  import cfgspi_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    spi_cs_n,
  input  logic                    spi_sclk,
  input  logic                    spi_sdio_i,
  output logic                    spi_sdio_o,
  output logic                    spi_sdio_oe,
  output logic                    ctl_pin_mode,
  output logic [NCH*FMT_W-1:0]    ch_fmt,
  output logic [NCH-1:0]          ch_ref_en,
  output logic [NCH*GAIN_W-1:0]   ch_ref_gain,
  output logic [NCH*TPSEL_W-1:0]  ch_tp_sel,
  output logic [NCH*TPWORD_W-1:0] ch_tp_word
);

  logic              cs_s, sclk_s, sdio_s, cs_fall, sclk_rise, sclk_fall;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  cfgspi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .cs_n(spi_cs_n), .sclk(spi_sclk), .sdio(spi_sdio_i),
    .cs_s(cs_s), .sclk_s(sclk_s), .sdio_s(sdio_s),
    .cs_fall(cs_fall), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
  );

  cfgspi_frame u_frame (
    .clk(clk), .rst(rst),
    .cs_s(cs_s), .sdio_s(sdio_s), .cs_fall(cs_fall),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdio_o(spi_sdio_o), .sdio_oe(spi_sdio_oe)
  );

  cfgspi_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst(rst),
    .cs_fall(cs_fall), .sclk_s(sclk_s),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .pin_mode(ctl_pin_mode),
    .ch_fmt(ch_fmt), .ch_ref_en(ch_ref_en), .ch_ref_gain(ch_ref_gain),
    .ch_tp_sel(ch_tp_sel), .ch_tp_word(ch_tp_word)
  );

endmodule

// File: tb/test_cfg_spi_slave.sv
`timescale 1ns/1ps
module test_cfg_spi_slave;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_cs_n = 1'b1;
  logic        spi_sclk = 1'b1;
  logic        spi_sdio_i = 1'b0;
  logic        spi_sdio_o, spi_sdio_oe, ctl_pin_mode;
  logic [3:0]  ch_fmt;
  logic [1:0]  ch_ref_en;
  logic [5:0]  ch_ref_gain;
  logic [5:0]  ch_tp_sel;
  logic [23:0] ch_tp_word;

  int checks = 0;
  int fails  = 0;
  localparam time HALF = 80ns;

  always #5ns clk = ~clk;

  cfg_spi_slave i_cfg_spi_slave (
    .clk(clk), .rst(rst),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_sdio_i(spi_sdio_i),
    .spi_sdio_o(spi_sdio_o), .spi_sdio_oe(spi_sdio_oe),
    .ctl_pin_mode(ctl_pin_mode),
    .ch_fmt(ch_fmt), .ch_ref_en(ch_ref_en), .ch_ref_gain(ch_ref_gain),
    .ch_tp_sel(ch_tp_sel), .ch_tp_word(ch_tp_word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bit_cycle(input logic b, output logic so);
    spi_sdio_i = b;
    #HALF;
    so = spi_sdio_o;
    spi_sclk = 1'b1;
    #HALF;
    spi_sclk = 1'b0;
  endtask

  // byte k of wdat/rdat sits at bits [8k+7:8k]
  task automatic xfer(input logic rw, input logic [1:0] len, input logic [12:0] addr,
                      input int nb, input logic [31:0] wdat,
                      output logic [31:0] rdat, output logic oe_seen);
    logic [15:0] ins;
    logic so;
    ins = {rw, len, addr};
    rdat = '0;
    oe_seen = 1'b0;
    spi_sclk = 1'b0;
    spi_cs_n = 1'b0;
    #HALF;
    for (int i = 15; i >= 0; i--) bit_cycle(ins[i], so);
    for (int k = 0; k < nb; k++) begin
      for (int i = 7; i >= 0; i--) begin
        bit_cycle(wdat[8*k+i], so);
        rdat[8*k+i] = so;
        if (k == 0 && i == 7) oe_seen = spi_sdio_oe;
      end
    end
    #HALF;
    spi_cs_n = 1'b1;
    #(2*HALF);
  endtask

  task automatic wr1(input logic [12:0] a, input logic [7:0] d);
    logic [31:0] r; logic o;
    xfer(1'b0, 2'b00, a, 1, {24'h0, d}, r, o);
  endtask

  task automatic rd1(input logic [12:0] a, output logic [7:0] d);
    logic [31:0] r; logic o;
    xfer(1'b1, 2'b00, a, 1, 32'h0, r, o);
    d = r[7:0];
  endtask

  task automatic t_reset_pinmode;
    chk("R1 pin mode after reset", ctl_pin_mode, 1);
    chk("R1 oe after reset", spi_sdio_oe, 0);
    chk("R1 pattern zero", ch_tp_word, 0);
    chk("R1 reference zero", {ch_ref_en, ch_ref_gain}, 0);
    chk("R2 format follows sclk high", ch_fmt, 4'b0101);
    spi_sclk = 1'b0;
    #(2*HALF);
    chk("R2 format follows sclk low", ch_fmt, 4'b0000);
    spi_sclk = 1'b1;
    #(2*HALF);
    spi_cs_n = 1'b0;
    #(2*HALF);
    spi_cs_n = 1'b1;
    #HALF;
    spi_sclk = 1'b0;
    #(2*HALF);
    chk("R2 pin mode left", ctl_pin_mode, 0);
    chk("R2 captured format", ch_fmt, 4'b0101);
    spi_sclk = 1'b1;
    #(2*HALF);
    spi_sclk = 1'b0;
    #(2*HALF);
    chk("R2 format no longer follows sclk", ch_fmt, 4'b0101);
    chk("R2 pin mode stays off", ctl_pin_mode, 0);
  endtask

  task automatic t_index_read;
    logic [31:0] r; logic o;
    xfer(1'b1, 2'b00, 13'h0003, 1, 32'h0, r, o);
    chk("R5 index reset read", r[7:0], 8'hFF);
    chk("R8 oe during read", o, 1);
    chk("R8 oe after cs high", spi_sdio_oe, 0);
  endtask

  task automatic t_ref_both;
    logic [7:0] d;
    wr1(13'h0008, 8'hFD);
    chk("R6 ref enable both", ch_ref_en, 2'b11);
    chk("R9 gain both", ch_ref_gain, 6'o55);
    rd1(13'h0008, d);
    chk("R9 ref readback unused zero", d, 8'h0D);
    wr1(13'h1008, 8'h02);
    chk("R3 upper address bits decode", {ch_ref_en, ch_ref_gain}, {2'b11, 6'o55});
  endtask

  task automatic t_steer;
    logic [7:0] d;
    wr1(13'h0003, 8'h02);
    wr1(13'h0011, 8'h02);
    chk("R6 write only channel B", ch_fmt, 4'b1001);
    rd1(13'h0003, d);
    chk("R5 reserved ones", d, 8'hFE);
    rd1(13'h0011, d);
    chk("R7 read B copy", d, 8'h02);
    wr1(13'h0003, 8'h01);
    rd1(13'h0011, d);
    chk("R7 read A copy", d, 8'h01);
    wr1(13'h0003, 8'h00);
    wr1(13'h0014, 8'h05);
    chk("R6 no channel selected", ch_tp_sel, 0);
    wr1(13'h0003, 8'h03);
    wr1(13'h0014, 8'h05);
    chk("R9 pattern select both", ch_tp_sel, 6'o55);
  endtask

  task automatic t_lengths;
    logic [31:0] r; logic o;
    xfer(1'b0, 2'b01, 13'h0016, 2, 32'h0000_BC0A, r, o);
    chk("R4 two-byte descending write", ch_tp_word, {12'hBCA, 12'hBCA});
    xfer(1'b0, 2'b00, 13'h0016, 2, 32'h0000_1103, r, o);
    chk("R4 extra byte ignored", ch_tp_word, {12'hBC3, 12'hBC3});
    xfer(1'b1, 2'b10, 13'h0016, 3, 32'h0, r, o);
    chk("R4 three-byte read", r[23:0], 24'h05BC03);
    xfer(1'b0, 2'b11, 13'h0016, 4, 32'h0106_5A07, r, o);
    chk("R4 streamed pattern", ch_tp_word, {12'h5A7, 12'h5A7});
    chk("R4 streamed select", ch_tp_sel, 6'o66);
    chk("R10 unmapped stream byte", ch_fmt, 4'b1001);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    wr1(13'h0100, 8'h55);
    rd1(13'h0100, d);
    chk("R10 unmapped read zero", d, 8'h00);
    rd1(13'h0013, d);
    chk("R10 unmapped near map read zero", d, 8'h00);
    chk("R10 state unchanged", {ch_ref_en, ch_ref_gain}, {2'b11, 6'o55});
  endtask

  initial begin
    #400us;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #(2*HALF);
    t_reset_pinmode();
    t_index_read();
    t_ref_both();
    t_steer();
    t_lengths();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule